// File: doc/BRIEF.md
# Receive Cipher Key Table with Address Lookup

This block keeps the per-peer cipher keys for a wireless MAC receive path and answers address lookups against them. The host loads the table through a 32-bit word-wide write port. Each table entry has eight words: five key words, a cipher-type word and two peer-address words. Storage is built from 64-bit rows. Each pair of words that shares a row, even word first and then odd word, is committed to the row as one unit. An even word is held in a staging register until the odd word of the same row arrives. The whole row is then written in one cycle, so a lookup never sees a half-updated key.

A peer address is stored shifted right by one bit. The low address word holds address bits 32:1. The high address word holds bits 47:33 in its low 15 bits, and bit 15 of that word is reused as the unicast flag. A lookup takes a received transmitter address and a group indication. One cycle later it returns the lowest matching entry index, that entry's cipher type and key words, and the key words of its integrity companion, which sits 64 entries higher.

Top module: `wkt_keytable`

## Requirements
- R1: The write and read address is {entry[7:0], word[2:0]}. The words are mapped as follows:
  - Words 0, 2 and 4 are 32-bit key words.
  - Words 1 and 3 keep only their bits 15:0.
  - Word 5 keeps only bits 2:0, which hold the cipher type.
  - Word 6 keeps all 32 bits.
  - Word 7 keeps only bits 15:0.
  - Discarded bits read back as zero.
- R2: A write to an even word changes no stored content. The following write to the odd word of the same entry and row commits both words in the same cycle.
- R3: A write to an odd word is ignored when the pending even word belongs to a different row, or when no even word is pending. A pending even word survives such an ignored write. A newer even write replaces the pending one.
- R4: A write whose entry field is 128 or more is ignored and leaves the pending even word untouched.
- R5: A commit of the type row is dropped when word 5 carries type code 4 (protected-integrity type) and the entry is 64 or higher.
- R6: rd_data shows, one cycle after rd_addr, the committed contents of the addressed word, never the pending even word. Entries of 128 or more read as zero.
- R7: An entry matches a lookup when all of the following hold:
  - its 47 stored address bits equal lk_addr[47:1];
  - its unicast flag (word 7 bit 15) equals the inverse of lk_group;
  - its unicast flag is set or its type is non-zero.
  
  Bit 0 of lk_addr is ignored. lk_done is high exactly in the cycle after lk_valid.
- R8: When several entries match, the lowest index is reported.
- R9: On a hit, lk_idx and lk_ctype give the matched entry, and lk_key gives {word4, word3, word2, word1, word0} with word 0 in the low bits. On a miss, lk_idx, lk_ctype, lk_key and lk_mic are zero.
- R10: lk_mic carries the entry at lk_idx+64 in the same word packing when lk_idx is below 64, and zero otherwise.
- R11: Writing type 0 and zero address words invalidates an entry for a lookup issued in the cycle right after the last commit.
- R12: After reset, all stored words read zero, lk_done and lk_hit are low, and no even word is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | 11 | Write address {entry, word} |
| wr_data | input | 32 | Write data |
| rd_addr | input | 11 | Readback address {entry, word} |
| rd_data | output | 32 | Readback data, one cycle later |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 48 | Received transmitter address |
| lk_group | input | 1 | 1 for a group-addressed frame |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | An entry matched |
| lk_idx | output | 7 | Matched entry index |
| lk_ctype | output | 3 | Matched cipher type |
| lk_key | output | 160 | Matched key words |
| lk_mic | output | 160 | Companion key words |

## Verification
The staging path is driven with four write orders:
- Even then odd on the same row commits both words.
- An odd word alone is dropped.
- An odd word on a foreign row is dropped while the earlier even word stays pending.
- An out-of-range even word between a pair of in-range writes is dropped and does not disturb the pending word.

Lookups are tried with a unicast hit, the same address flagged as group, an address differing only in bit 0, two group entries sharing one address, and a group lookup of address zero. Together these separate the flag comparison, the ignored bit, the lowest-index priority and the companion rule at indices above 63. A lookup issued in the cycle right after an invalidating commit shows whether the invalidation takes effect without delay.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned ROW_W    = 64;
  localparam int unsigned ROWS_ENT = 4;
  localparam int unsigned ADDR_W   = 48;
  localparam int unsigned CT_W     = 3;
  localparam int unsigned KEYV_W   = 160;

  typedef enum logic [CT_W-1:0] {
    CT_CLEAR  = 3'd0,
    CT_WEP40  = 3'd1,
    CT_WEP104 = 3'd2,
    CT_WEP128 = 3'd3,
    CT_TKIP   = 3'd4,
    CT_AESOCB = 3'd5,
    CT_CCM    = 3'd6
  } ctype_e;

  // row numbers inside an entry: words 2r and 2r+1 share row r
  localparam logic [1:0] ROW_K01  = 2'd0;
  localparam logic [1:0] ROW_K23  = 2'd1;
  localparam logic [1:0] ROW_K4CT = 2'd2;
  localparam logic [1:0] ROW_ADDR = 2'd3;
endpackage

// File: rtl/wkt_stage.sv
module wkt_stage
  import wkt_pkg::*;
#(
  parameter int unsigned ENTRIES = 128,
  parameter int unsigned MIC_OFS = 64,
  parameter int unsigned EIDX_W  = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned WA_W   = EIDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [WA_W-1:0]   wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic              commit_o,
  output logic [IDX_W-1:0]  commit_ent_o,
  output logic [1:0]        commit_row_o,
  output logic [ROW_W-1:0]  commit_data_o
);
  localparam logic [EIDX_W:0] ENT_LIM  = (EIDX_W+1)'(ENTRIES);
  localparam logic [EIDX_W:0] TKIP_LIM = (EIDX_W+1)'(ENTRIES - MIC_OFS);

  logic [EIDX_W-1:0] w_ent;
  logic [1:0]        w_row;
  logic              w_odd, w_inrange, w_tkip_bad;
  logic [WORD_W-1:0] odd_masked;

  logic              stg_vld_q, stg_vld_d;
  logic [IDX_W-1:0]  stg_ent_q, stg_ent_d;
  logic [1:0]        stg_row_q, stg_row_d;
  logic [WORD_W-1:0] stg_dat_q, stg_dat_d;
  logic              stg_en;

  assign w_ent     = wr_addr_i[WA_W-1:3];
  assign w_row     = wr_addr_i[2:1];
  assign w_odd     = wr_addr_i[0];
  assign w_inrange = {1'b0, w_ent} < ENT_LIM;

  always_comb begin
    case (w_row)
      ROW_K4CT: odd_masked = {{(WORD_W-CT_W){1'b0}}, wr_data_i[CT_W-1:0]};
      default:  odd_masked = {16'h0000, wr_data_i[15:0]};
    endcase
  end

  assign w_tkip_bad = (w_row == ROW_K4CT) && (odd_masked[CT_W-1:0] == CT_TKIP)
                      && ({1'b0, w_ent} >= TKIP_LIM);

  always_comb begin
    stg_vld_d = stg_vld_q;
    stg_ent_d = stg_ent_q;
    stg_row_d = stg_row_q;
    stg_dat_d = stg_dat_q;
    commit_o  = 1'b0;
    if (wr_en_i && w_inrange) begin
      if (!w_odd) begin
        stg_vld_d = 1'b1;
        stg_ent_d = w_ent[IDX_W-1:0];
        stg_row_d = w_row;
        stg_dat_d = wr_data_i;
      end else if (stg_vld_q && stg_ent_q == w_ent[IDX_W-1:0] && stg_row_q == w_row) begin
        stg_vld_d = 1'b0;
        commit_o  = !w_tkip_bad;
      end
    end
  end

  assign stg_en        = wr_en_i && w_inrange;
  assign commit_ent_o  = stg_ent_q;
  assign commit_row_o  = stg_row_q;
  assign commit_data_o = {odd_masked, stg_dat_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_vld_q <= 1'b0;
      stg_ent_q <= '0;
      stg_row_q <= '0;
      stg_dat_q <= '0;
    end else if (stg_en) begin
      stg_vld_q <= stg_vld_d;
      stg_ent_q <= stg_ent_d;
      stg_row_q <= stg_row_d;
      stg_dat_q <= stg_dat_d;
    end
  end

  assert_commit_on_odd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (wr_en_i && w_odd && stg_vld_q));
  assert_upper_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o && commit_row_o != ROW_K4CT) |-> (commit_data_o[ROW_W-1:48] == 16'h0000));
  assert_no_high_tkip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_o && commit_row_o == ROW_K4CT && {1'b0, w_ent} >= TKIP_LIM)
      |-> (commit_data_o[WORD_W+CT_W-1:WORD_W] != CT_TKIP));
  assert_stage_kept_oor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !w_inrange) |=> $stable(stg_dat_q) && $stable(stg_vld_q));
endmodule

// File: rtl/wkt_store.sv
module wkt_store
  import wkt_pkg::*;
#(
  parameter int unsigned ENTRIES = 128,
  parameter int unsigned MIC_OFS = 64,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned NROWS  = ENTRIES * ROWS_ENT,
  localparam int unsigned RX_W   = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [IDX_W-1:0]  commit_ent_i,
  input  logic [1:0]        commit_row_i,
  input  logic [ROW_W-1:0]  commit_data_i,
  input  logic [IDX_W-1:0]  rd_ent_i,
  input  logic [1:0]        rd_row_i,
  output logic [ROW_W-1:0]  rd_row_o,
  input  logic [IDX_W-1:0]  lk_ent_i,
  output logic [KEYV_W-1:0] lk_key_o,
  output logic [KEYV_W-1:0] lk_mic_o,
  output logic [47:0]       addr_row_o [ENTRIES],
  output logic [CT_W-1:0]   ctype_o [ENTRIES]
);
  localparam logic [IDX_W-1:0] MIC_LIM = IDX_W'(ENTRIES - MIC_OFS);
  localparam logic [IDX_W-1:0] MIC_ADD = IDX_W'(MIC_OFS);

  logic [ROW_W-1:0] mem_q [NROWS];
  logic [RX_W-1:0]  wr_ix;
  logic [IDX_W-1:0] mic_ent;
  logic [ROW_W-1:0] k01, k23, k4c, m01, m23, m4c;

  assign wr_ix = {commit_ent_i, commit_row_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NROWS; i++) mem_q[i] <= '0;
    end else if (commit_i) begin
      mem_q[wr_ix] <= commit_data_i;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_tap
    assign addr_row_o[g] = mem_q[g*ROWS_ENT + ROW_ADDR][47:0];
    assign ctype_o[g]    = mem_q[g*ROWS_ENT + ROW_K4CT][WORD_W+CT_W-1:WORD_W];
  end

  assign rd_row_o = mem_q[{rd_ent_i, rd_row_i}];
  assign mic_ent  = lk_ent_i + MIC_ADD;

  always_comb begin
    k01 = mem_q[{lk_ent_i, ROW_K01}];
    k23 = mem_q[{lk_ent_i, ROW_K23}];
    k4c = mem_q[{lk_ent_i, ROW_K4CT}];
    m01 = mem_q[{mic_ent, ROW_K01}];
    m23 = mem_q[{mic_ent, ROW_K23}];
    m4c = mem_q[{mic_ent, ROW_K4CT}];
    lk_key_o = {k4c[WORD_W-1:0], k23, k01};
    if (lk_ent_i < MIC_LIM) lk_mic_o = {m4c[WORD_W-1:0], m23, m01};
    else                    lk_mic_o = '0;
  end

  assert_row_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> (mem_q[$past(wr_ix)] == $past(commit_data_i)));
endmodule

// File: rtl/wkt_match.sv
module wkt_match
  import wkt_pkg::*;
#(
  parameter int unsigned ENTRIES = 128,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [46:0]      key_addr_i,
  input  logic             group_i,
  input  logic [47:0]      addr_row_i [ENTRIES],
  input  logic [CT_W-1:0]  ctype_i [ENTRIES],
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [ENTRIES-1:0] cand;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign cand[g] = (addr_row_i[g][46:0] == key_addr_i)
                     && (addr_row_i[g][47] == !group_i)
                     && (addr_row_i[g][47] || (ctype_i[g] != CT_CLEAR));
  end

  always_comb begin
    hit_o = |cand;
    idx_o = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (cand[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/wkt_keytable.sv
module wkt_keytable
  import wkt_pkg::*;
#(
  parameter int unsigned ENTRIES = 128,
  parameter int unsigned MIC_OFS = 64,
  parameter int unsigned EIDX_W  = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned WA_W   = EIDX_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WA_W-1:0]   wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [WA_W-1:0]   rd_addr,
  output logic [31:0]       rd_data,
  input  logic              lk_valid,
  input  logic [47:0]       lk_addr,
  input  logic              lk_group,
  output logic              lk_done,
  output logic              lk_hit,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [2:0]        lk_ctype,
  output logic [159:0]      lk_key,
  output logic [159:0]      lk_mic
);
  localparam logic [EIDX_W:0]  ENT_LIM = (EIDX_W+1)'(ENTRIES);
  localparam logic [IDX_W-1:0] MIC_LIM = IDX_W'(ENTRIES - MIC_OFS);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  logic              st_commit;
  logic [IDX_W-1:0]  st_ent;
  logic [1:0]        st_row;
  logic [ROW_W-1:0]  st_data;

  wkt_stage #(.ENTRIES(ENTRIES), .MIC_OFS(MIC_OFS), .EIDX_W(EIDX_W)) u_stage (
    .clk(clk), .rst_n(arst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .commit_o(st_commit), .commit_ent_o(st_ent), .commit_row_o(st_row), .commit_data_o(st_data)
  );

  logic [EIDX_W-1:0]  rd_ent;
  logic               rd_inrange;
  logic [ROW_W-1:0]   rd_row;
  logic [IDX_W-1:0]   m_idx;
  logic               m_hit;
  logic [KEYV_W-1:0]  s_key, s_mic;
  logic [47:0]        addr_row [ENTRIES];
  logic [CT_W-1:0]    ctype    [ENTRIES];
  logic               unused_lk_bit0;

  assign rd_ent         = rd_addr[WA_W-1:3];
  assign rd_inrange     = {1'b0, rd_ent} < ENT_LIM;
  assign unused_lk_bit0 = lk_addr[0];

  wkt_store #(.ENTRIES(ENTRIES), .MIC_OFS(MIC_OFS)) u_store (
    .clk(clk), .rst_n(arst_n),
    .commit_i(st_commit), .commit_ent_i(st_ent), .commit_row_i(st_row), .commit_data_i(st_data),
    .rd_ent_i(rd_ent[IDX_W-1:0]), .rd_row_i(rd_addr[2:1]), .rd_row_o(rd_row),
    .lk_ent_i(m_idx), .lk_key_o(s_key), .lk_mic_o(s_mic),
    .addr_row_o(addr_row), .ctype_o(ctype)
  );

  wkt_match #(.ENTRIES(ENTRIES)) u_match (
    .key_addr_i(lk_addr[47:1]), .group_i(lk_group),
    .addr_row_i(addr_row), .ctype_i(ctype),
    .hit_o(m_hit), .idx_o(m_idx)
  );

  logic [31:0]       rd_d;
  logic              hit_d;
  logic [IDX_W-1:0]  idx_d;
  logic [CT_W-1:0]   ct_d;
  logic [KEYV_W-1:0] key_d, mic_d;

  always_comb begin
    if (!rd_inrange)     rd_d = '0;
    else if (rd_addr[0]) rd_d = rd_row[ROW_W-1:WORD_W];
    else                 rd_d = rd_row[WORD_W-1:0];
    hit_d = m_hit;
    idx_d = m_hit ? m_idx : '0;
    ct_d  = m_hit ? ctype[m_idx] : CT_CLEAR;
    key_d = m_hit ? s_key : '0;
    mic_d = m_hit ? s_mic : '0;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rd_data <= '0;
      lk_done <= 1'b0;
    end else begin
      rd_data <= rd_d;
      lk_done <= lk_valid;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      lk_hit   <= 1'b0;
      lk_idx   <= '0;
      lk_ctype <= '0;
      lk_key   <= '0;
      lk_mic   <= '0;
    end else if (lk_valid) begin
      lk_hit   <= hit_d;
      lk_idx   <= idx_d;
      lk_ctype <= ct_d;
      lk_key   <= key_d;
      lk_mic   <= mic_d;
    end
  end

  assert_done_follows_R7: assert property (@(posedge clk) disable iff (!arst_n)
    lk_valid |=> lk_done);
  assert_done_drops_R7: assert property (@(posedge clk) disable iff (!arst_n)
    !lk_valid |=> !lk_done);
  assert_flag_class_R7: assert property (@(posedge clk) disable iff (!arst_n)
    (lk_valid && !st_commit) |=> (!lk_hit || (addr_row[lk_idx][47] == !$past(lk_group))));
  assert_miss_zero_R9: assert property (@(posedge clk) disable iff (!arst_n)
    (lk_done && !lk_hit) |-> (lk_key == '0 && lk_mic == '0 && lk_ctype == '0 && lk_idx == '0));
  assert_mic_upper_zero_R10: assert property (@(posedge clk) disable iff (!arst_n)
    (lk_done && lk_hit && lk_idx >= MIC_LIM) |-> (lk_mic == '0));
endmodule

// File: tb/wkt_keytable_bench.sv
module wkt_keytable_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk, rst_n, wr_en, lk_valid, lk_group;
  logic [10:0]  wr_addr, rd_addr;
  logic [31:0]  wr_data, rd_data;
  logic [47:0]  lk_addr;
  logic         lk_done, lk_hit;
  logic [6:0]   lk_idx;
  logic [2:0]   lk_ctype;
  logic [159:0] lk_key, lk_mic;

  int checks = 0;
  int errors = 0;
  bit fin = 0;

  wkt_keytable u_wkt_keytable (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .lk_valid(lk_valid), .lk_addr(lk_addr),
    .lk_group(lk_group), .lk_done(lk_done), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_ctype(lk_ctype), .lk_key(lk_key), .lk_mic(lk_mic)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [10:0] wa(input int e, input int w);
    return {e[7:0], w[2:0]};
  endfunction

  localparam logic [47:0] MAC_A = 48'h0A1B_2C3D_4E5F;
  localparam logic [47:0] MAC_B = 48'h5544_3322_1101;
  localparam logic [31:0] A_LO  = MAC_A[32:1];
  localparam logic [15:0] A_HI  = {1'b1, MAC_A[47:33]};
  localparam logic [159:0] KEY5 = {32'h55555555, 32'h00004444, 32'h33333333, 32'h00002222, 32'h11111111};
  localparam logic [159:0] MIC5 = {32'hE4E4E4E4, 32'h0000D3D3, 32'hC2C2C2C2, 32'h0000B1B1, 32'hA0A0A0A0};

  typedef struct packed {
    logic        we;
    logic [10:0] wa;
    logic [31:0] wd;
    logic [10:0] ra;
    logic [31:0] ex;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b1, wa(5,0),   32'h11111111,        wa(5,0),   32'h0,        4'd2}, // R2 even held
    '{1'b1, wa(5,1),   32'hABCD2222,        wa(5,0),   32'h11111111, 4'd2}, // R2 pair commits
    '{1'b0, wa(0,0),   32'h0,               wa(5,1),   32'h00002222, 4'd1}, // R1 16-bit word
    '{1'b1, wa(5,2),   32'h33333333,        wa(5,2),   32'h0,        4'd2}, // R2
    '{1'b1, wa(5,3),   32'hFFFF4444,        wa(5,3),   32'h00004444, 4'd1}, // R1
    '{1'b1, wa(5,4),   32'h55555555,        wa(5,4),   32'h0,        4'd2}, // R2
    '{1'b1, wa(5,5),   32'hFFFFFFFC,        wa(5,5),   32'h4,        4'd1}, // R1 type 3 bits
    '{1'b0, wa(0,0),   32'h0,               wa(5,4),   32'h55555555, 4'd2}, // R2
    '{1'b1, wa(5,6),   A_LO,                wa(5,6),   32'h0,        4'd2}, // R2
    '{1'b1, wa(5,7),   {16'hFFFF, A_HI},    wa(5,7),   {16'h0,A_HI}, 4'd1}, // R1
    '{1'b0, wa(0,0),   32'h0,               wa(5,6),   A_LO,         4'd6}, // R6
    '{1'b1, wa(6,1),   32'h00000099,        wa(6,1),   32'h0,        4'd3}, // R3 lone odd
    '{1'b1, wa(6,0),   32'h00000077,        wa(6,0),   32'h0,        4'd2}, // R2
    '{1'b1, wa(7,1),   32'h00000088,        wa(7,1),   32'h0,        4'd3}, // R3 foreign row
    '{1'b1, wa(6,1),   32'h00001234,        wa(6,0),   32'h00000077, 4'd3}, // R3 stage kept
    '{1'b0, wa(0,0),   32'h0,               wa(6,1),   32'h00001234, 4'd3}, // R3
    '{1'b1, wa(8,0),   32'h00C0FFEE,        wa(8,0),   32'h0,        4'd2}, // R2
    '{1'b1, wa(200,0), 32'h00000BAD,        wa(200,0), 32'h0,        4'd4}, // R4 out of range
    '{1'b1, wa(8,1),   32'h00000001,        wa(8,0),   32'h00C0FFEE, 4'd4}, // R4 stage untouched
    '{1'b1, wa(100,4), 32'h00000005,        wa(100,4), 32'h0,        4'd2}, // R2
    '{1'b1, wa(100,5), 32'h00000004,        wa(100,5), 32'h0,        4'd5}, // R5 dropped
    '{1'b0, wa(0,0),   32'h0,               wa(100,4), 32'h0,        4'd5}, // R5 key half too
    '{1'b1, wa(100,4), 32'h00000005,        wa(100,4), 32'h0,        4'd2}, // R2
    '{1'b1, wa(100,5), 32'h00000005,        wa(100,5), 32'h5,        4'd5}, // R5 other type ok
    '{1'b1, wa(69,0),  32'hA0A0A0A0,        wa(69,0),  32'h0,        4'd2}, // R2
    '{1'b1, wa(69,1),  32'h0000B1B1,        wa(69,1),  32'h0000B1B1, 4'd2}, // R2
    '{1'b1, wa(69,2),  32'hC2C2C2C2,        wa(69,2),  32'h0,        4'd2}, // R2
    '{1'b1, wa(69,3),  32'h0000D3D3,        wa(69,3),  32'h0000D3D3, 4'd2}, // R2
    '{1'b1, wa(69,4),  32'hE4E4E4E4,        wa(69,4),  32'h0,        4'd2}, // R2
    '{1'b1, wa(69,5),  32'h00000000,        wa(69,4),  32'hE4E4E4E4, 4'd2}  // R2
  };

  task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input int e, input int w, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = wa(e, w); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int e, input int w, input logic [31:0] exp, input string req);
    rd_addr = wa(e, w);
    @(negedge clk);
    chk(req, {128'h0, rd_data}, {128'h0, exp});
  endtask

  task automatic lk(input logic [47:0] a, input logic g);
    lk_valid = 1'b1; lk_addr = a; lk_group = g;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic prog(input int e, input logic [2:0] ct, input logic [47:0] mac, input logic uni);
    wr(e, 4, 32'h0);
    wr(e, 5, {29'h0, ct});
    wr(e, 6, mac[32:1]);
    wr(e, 7, {16'h0, uni, mac[47:33]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      errors++;
      $display("FAIL R12 watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    lk_valid = 1'b0; lk_addr = '0; lk_group = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 rd_data in reset", {128'h0, rd_data}, 160'h0);
    chk("R12 lk_done in reset", {159'h0, lk_done}, 160'h0);
    chk("R12 lk_hit in reset",  {159'h0, lk_hit},  160'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].we) begin
        wr_en = 1'b1; wr_addr = VECS[i].wa; wr_data = VECS[i].wd;
      end
      @(negedge clk);
      wr_en = 1'b0;
      rd_addr = VECS[i].ra;
      @(negedge clk);
      chk($sformatf("R%0d vector %0d", VECS[i].rq, i), {128'h0, rd_data}, {128'h0, VECS[i].ex});
    end

    // unicast hit with companion (R7 R9 R10)
    lk(MAC_A, 1'b0);
    chk("R7 done",        {159'h0, lk_done}, 160'h1);
    chk("R7 hit",         {159'h0, lk_hit},  160'h1);
    chk("R9 idx",         {153'h0, lk_idx},  160'd5);
    chk("R9 ctype",       {157'h0, lk_ctype}, 160'd4);
    chk("R9 key",         lk_key, KEY5);
    chk("R10 companion",  lk_mic, MIC5);
    @(negedge clk);
    chk("R7 done drops",  {159'h0, lk_done}, 160'h0);

    // bit 0 ignored (R7)
    lk(MAC_A ^ 48'h1, 1'b0);
    chk("R7 bit0 ignored", {152'h0, lk_hit, lk_idx}, {152'h0, 1'b1, 7'd5});

    // unicast entry refused for group (R7 R9)
    lk(MAC_A, 1'b1);
    chk("R7 group vs unicast", {159'h0, lk_hit}, 160'h0);
    chk("R9 miss key zero", lk_key, 160'h0);
    chk("R9 miss mic zero", lk_mic, 160'h0);
    chk("R9 miss idx ctype", {150'h0, lk_idx, lk_ctype}, 160'h0);

    // lowest index wins (R8)
    prog(9, 3'd1, MAC_B, 1'b0);
    prog(2, 3'd2, MAC_B, 1'b0);
    lk(MAC_B, 1'b1);
    chk("R8 lowest index", {149'h0, lk_hit, lk_idx, lk_ctype}, {149'h0, 1'b1, 7'd2, 3'd2});
    lk(MAC_B, 1'b0);
    chk("R7 group entry refused unicast", {159'h0, lk_hit}, 160'h0);

    // invalidate entry 2, look up in the next cycle (R11)
    wr(2, 4, 32'h0);
    wr(2, 5, 32'h0);
    wr(2, 6, 32'h0);
    wr(2, 7, 32'h0);
    lk(MAC_B, 1'b1);
    chk("R11 invalidated skipped", {149'h0, lk_hit, lk_idx, lk_ctype}, {149'h0, 1'b1, 7'd9, 3'd1});

    // group lookup of zero address: companion 69 never matches, entry 100 does (R7 R10)
    lk(48'h0, 1'b1);
    chk("R7 companion not matched", {152'h0, lk_hit, lk_idx}, {152'h0, 1'b1, 7'd100});
    chk("R9 key entry 100", lk_key, {32'h5, 128'h0});
    chk("R10 no companion above 63", lk_mic, 160'h0);

    // reset clears storage (R12)
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(5, 0, 32'h0, "R12 storage cleared");
    lk(MAC_A, 1'b0);
    chk("R12 lookup misses after reset", {159'h0, lk_hit}, 160'h0);

    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule